// File: doc/BRIEF.md
# Clustered Packet Fan-Out Switch

This block sits in front of a cluster of four packet processors. Several wide streaming inputs (512-bit beats) each carry packets together with a small destination tag. The switch delivers each packet, whole and in order, to one of four narrow output links (128-bit beats). Each narrow link runs at one quarter of the width of an input. The tag picks the link. Something upstream assigns the tags, so the switch only honours them.

Each input owns a small FIFO followed by a narrowing stage. The FIFO absorbs wide beats and the narrowing stage splits the head beat into narrow lanes. A slow or stalled output therefore backs up only the inputs aimed at it. Every output has its own round-robin arbiter. The arbiter matters only when several inputs hold a packet for the same link at the same time. Once it grants an input, it keeps that grant until the packet's final narrow beat has been accepted.

Three small state machines do the work:
- **Per-input tag tracker** (`IN_FIRST`, `IN_BODY`). It takes the tag on a packet's opening beat. It moves `IN_FIRST`→`IN_BODY` on an accepted beat without last, and `IN_BODY`→`IN_FIRST` on an accepted beat with last.
- **Narrowing stage** (`CV_HEAD`, `CV_TAIL`). It moves `CV_HEAD`→`CV_TAIL` when lane 0 is accepted and is not the end of the wide beat. It stays in `CV_TAIL` while it steps through lanes. It returns `CV_TAIL`→`CV_HEAD` when the final lane of the beat is accepted.
- **Per-output arbiter** (`ARB_IDLE`, `ARB_LOCK`). It moves `ARB_IDLE`→`ARB_LOCK` when any input requests it, locking the round-robin winner. It moves `ARB_LOCK`→`ARB_IDLE` when the narrow beat carrying last is accepted, and its pointer then moves one input past the finished winner.

Top module: `pkt_fanout_switch`

## Requirements
- R1: While reset is held and right after it is released, every `m_valid` is 0 and every `s_ready` is 1.
- R2: A packet is delivered only on output number `s_dest` (a binary index from 0 to 3) and appears on no other output.
- R3: The tag is taken from the first beat of a packet. The `s_dest` value on any later beat of that packet has no effect on routing.
- R4: A wide beat is sent as narrow beats in lane order. Lane 0 comes first and is bits [127:0], with keep bits [15:0]. Lane k is bits [128k+127:128k], with keep bits [16k+15:16k]. A beat that is not the last of its packet yields all four lanes.
- R5: The last wide beat must have a contiguous keep starting at byte 0 with at least one byte set. It yields lanes only up to the highest lane that has any keep bit set. That lane carries `m_last`=1 and its own keep slice.
- R6: Packets never interleave on an output. Once an output starts a packet, every narrow beat up to its last comes from the same packet.
- R7: When several inputs contend for one output, grants rotate round-robin. After a packet from input i finishes, the next grant goes to the first requesting input after i, wrapping around. The pointer starts at input 0 after reset.
- R8: Each input FIFO holds FIFO_DEPTH wide beats. `s_ready` drops to 0 when the FIFO is full and no beat is accepted while it is low.
- R9: An output whose sink holds `m_ready` low does not block traffic from other inputs to other outputs.
- R10: While `m_valid` is 1 and `m_ready` is 0, that output's valid, data, keep and last stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | N_IN | Per-input beat valid |
| s_ready | output | N_IN | Per-input ready (low when that FIFO is full) |
| s_data | input | N_IN x WIDE_W | Per-input wide data |
| s_keep | input | N_IN x WIDE_W/8 | Per-input byte keep |
| s_last | input | N_IN | Per-input final beat of packet |
| s_dest | input | N_IN x clog2(N_OUT) | Per-input output index, read on first beat |
| m_valid | output | N_OUT | Per-output beat valid |
| m_ready | input | N_OUT | Per-output sink ready |
| m_data | output | N_OUT x NARROW_W | Per-output narrow data |
| m_keep | output | N_OUT x NARROW_W/8 | Per-output byte keep |
| m_last | output | N_OUT | Per-output final beat of packet |

## Verification
Each kind of fault shows up at the ports in its own way:

| Internal fault | What shows at the ports | How soon |
|---|---|---|
| Bad lane counter in the narrowing stage | Repeated or skipped lanes, or `m_last` on the wrong lane | On the very next packet |
| Lost or stale tag | A whole packet lands on the wrong link | At once |
| Wrong arbiter pointer or a lock that releases early | Contending packets come out in the wrong order, or beats of two packets mix | Within one packet time |
| FIFO count error | `s_ready` falls too early or too late under a stalled sink, or a beat is dropped | Visible as a short or missing packet |

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    // per-input tag tracking
    typedef enum logic {
        IN_FIRST,
        IN_BODY
    } ing_state_e;

    // narrowing stage: lane 0 pending, or a later lane pending
    typedef enum logic {
        CV_HEAD,
        CV_TAIL
    } cv_state_e;

    // per-output arbiter
    typedef enum logic {
        ARB_IDLE,
        ARB_LOCK
    } arb_state_e;

endpackage

// File: rtl/pfs_ingress.sv
module pfs_ingress
    import pfs_pkg::*;
#(
    parameter int WIDE_W = 512,
    parameter int DEST_W = 2,
    parameter int DEPTH  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s_valid,
    output logic                 s_ready,
    input  logic [WIDE_W-1:0]    s_data,
    input  logic [WIDE_W/8-1:0]  s_keep,
    input  logic                 s_last,
    input  logic [DEST_W-1:0]    s_dest,
    output logic                 h_valid,
    output logic [WIDE_W-1:0]    h_data,
    output logic [WIDE_W/8-1:0]  h_keep,
    output logic                 h_last,
    output logic [DEST_W-1:0]    h_dest,
    input  logic                 pop
);

    localparam int KEEP_W = WIDE_W / 8;
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    ing_state_e          state, state_nx;
    logic [DEST_W-1:0]   dest_hold, dest_hold_nx;
    logic [DEST_W-1:0]   eff_dest;
    logic                push;

    logic [WIDE_W-1:0]   mem_data [DEPTH];
    logic [KEEP_W-1:0]   mem_keep [DEPTH];
    logic                mem_last [DEPTH];
    logic [DEST_W-1:0]   mem_dest [DEPTH];
    logic [PTR_W-1:0]    wr_ptr, rd_ptr;
    logic [CNT_W-1:0]    cnt;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= IN_FIRST;
            dest_hold <= '0;
        end else begin
            state     <= state_nx;
            dest_hold <= dest_hold_nx;
        end
    end

    // next state
    always_comb begin
        state_nx     = state;
        dest_hold_nx = dest_hold;
        unique case (state)
            IN_FIRST: begin
                if (push && !s_last) begin
                    state_nx     = IN_BODY;
                    dest_hold_nx = s_dest;
                end
            end
            IN_BODY: begin
                if (push && s_last) begin
                    state_nx = IN_FIRST;
                end
            end
            default: state_nx = IN_FIRST;
        endcase
    end

    // outputs
    always_comb begin
        s_ready  = (cnt != CNT_W'(DEPTH));
        push     = s_valid && s_ready;
        eff_dest = (state == IN_FIRST) ? s_dest : dest_hold;
        h_valid  = (cnt != '0);
        h_data   = mem_data[rd_ptr];
        h_keep   = mem_keep[rd_ptr];
        h_last   = mem_last[rd_ptr];
        h_dest   = mem_dest[rd_ptr];
    end

    // storage
    always_ff @(posedge clk) begin
        if (push) begin
            mem_data[wr_ptr] <= s_data;
            mem_keep[wr_ptr] <= s_keep;
            mem_last[wr_ptr] <= s_last;
            mem_dest[wr_ptr] <= eff_dest;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= ptr_inc(wr_ptr);
            if (pop)  rd_ptr <= ptr_inc(rd_ptr);
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/pfs_narrower.sv
module pfs_narrower
    import pfs_pkg::*;
#(
    parameter int WIDE_W   = 512,
    parameter int NARROW_W = 128,
    parameter int DEST_W   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  h_valid,
    input  logic [WIDE_W-1:0]     h_data,
    input  logic [WIDE_W/8-1:0]   h_keep,
    input  logic                  h_last,
    input  logic [DEST_W-1:0]     h_dest,
    output logic                  pop,
    output logic                  n_valid,
    input  logic                  n_ready,
    output logic [NARROW_W-1:0]   n_data,
    output logic [NARROW_W/8-1:0] n_keep,
    output logic                  n_last,
    output logic [DEST_W-1:0]     n_dest
);

    localparam int RATIO   = WIDE_W / NARROW_W;
    localparam int NKEEP_W = NARROW_W / 8;
    localparam int LANE_W  = (RATIO > 1) ? $clog2(RATIO) : 1;

    cv_state_e           state, state_nx;
    logic [LANE_W-1:0]   lane, lane_nx;
    logic [LANE_W-1:0]   cur;
    logic                nxt_has;
    logic                beat_end;
    logic                accept;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CV_HEAD;
            lane  <= '0;
        end else begin
            state <= state_nx;
            lane  <= lane_nx;
        end
    end

    // lane selection and end-of-beat detection
    always_comb begin
        cur     = (state == CV_HEAD) ? '0 : lane;
        n_data  = '0;
        n_keep  = '0;
        nxt_has = 1'b0;
        for (int k = 0; k < RATIO; k++) begin
            if (LANE_W'(k) == cur) begin
                n_data = h_data[k*NARROW_W +: NARROW_W];
                n_keep = h_keep[k*NKEEP_W +: NKEEP_W];
            end
            if (k > 0) begin
                if (LANE_W'(k - 1) == cur) begin
                    nxt_has = |h_keep[k*NKEEP_W +: NKEEP_W];
                end
            end
        end
        beat_end = (cur == LANE_W'(RATIO - 1)) || (h_last && !nxt_has);
    end

    // outputs
    always_comb begin
        n_valid = h_valid;
        n_last  = h_last && beat_end;
        n_dest  = h_dest;
        accept  = h_valid && n_ready;
        pop     = accept && beat_end;
    end

    // next state
    always_comb begin
        state_nx = state;
        lane_nx  = lane;
        unique case (state)
            CV_HEAD: begin
                if (accept && !beat_end) begin
                    state_nx = CV_TAIL;
                    lane_nx  = LANE_W'(1);
                end
            end
            CV_TAIL: begin
                if (accept) begin
                    if (beat_end) begin
                        state_nx = CV_HEAD;
                        lane_nx  = '0;
                    end else begin
                        lane_nx  = lane + 1'b1;
                    end
                end
            end
            default: state_nx = CV_HEAD;
        endcase
    end

endmodule

// File: rtl/pfs_out_arb.sv
module pfs_out_arb
    import pfs_pkg::*;
#(
    parameter int N_IN     = 3,
    parameter int NARROW_W = 128,
    parameter int DEST_W   = 2,
    parameter int OUT_ID   = 0
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [N_IN-1:0]                      n_valid,
    input  logic [N_IN-1:0][DEST_W-1:0]          n_dest,
    input  logic [N_IN-1:0][NARROW_W-1:0]        n_data,
    input  logic [N_IN-1:0][NARROW_W/8-1:0]      n_keep,
    input  logic [N_IN-1:0]                      n_last,
    output logic                                 m_valid,
    input  logic                                 m_ready,
    output logic [NARROW_W-1:0]                  m_data,
    output logic [NARROW_W/8-1:0]                m_keep,
    output logic                                 m_last,
    output logic [N_IN-1:0]                      gnt,
    output logic [N_IN-1:0]                      gnt_ready
);

    localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1;

    arb_state_e          state, state_nx;
    logic [IDX_W-1:0]    owner, owner_nx;
    logic [IDX_W-1:0]    ptr, ptr_nx;
    logic [N_IN-1:0]     req;
    logic [IDX_W-1:0]    pick, pick_hi, pick_lo;
    logic                found_hi, found_lo;
    logic                done;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ARB_IDLE;
            owner <= '0;
            ptr   <= '0;
        end else begin
            state <= state_nx;
            owner <= owner_nx;
            ptr   <= ptr_nx;
        end
    end

    // round-robin pick: lowest requester at or above ptr, else lowest overall
    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            req[i] = n_valid[i] && (n_dest[i] == DEST_W'(OUT_ID));
        end
        pick_hi  = '0;
        pick_lo  = '0;
        found_hi = 1'b0;
        found_lo = 1'b0;
        for (int i = N_IN - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick_lo  = IDX_W'(i);
                found_lo = 1'b1;
                if (IDX_W'(i) >= ptr) begin
                    pick_hi  = IDX_W'(i);
                    found_hi = 1'b1;
                end
            end
        end
        pick = found_hi ? pick_hi : pick_lo;
    end

    // outputs
    always_comb begin
        m_data = '0;
        m_keep = '0;
        m_last = 1'b0;
        for (int i = 0; i < N_IN; i++) begin
            gnt[i] = (state == ARB_LOCK) && (owner == IDX_W'(i));
            gnt_ready[i] = gnt[i] && m_ready;
            if (gnt[i]) begin
                m_data = n_data[i];
                m_keep = n_keep[i];
                m_last = n_last[i];
            end
        end
        m_valid = |(gnt & n_valid);
        done    = m_valid && m_ready && m_last;
    end

    // next state
    always_comb begin
        state_nx = state;
        owner_nx = owner;
        ptr_nx   = ptr;
        unique case (state)
            ARB_IDLE: begin
                if ((|req) && found_lo) begin
                    state_nx = ARB_LOCK;
                    owner_nx = pick;
                end
            end
            ARB_LOCK: begin
                if (done) begin
                    state_nx = ARB_IDLE;
                    ptr_nx   = (owner == IDX_W'(N_IN - 1)) ? '0 : owner + 1'b1;
                end
            end
            default: state_nx = ARB_IDLE;
        endcase
    end

endmodule

// File: rtl/pkt_fanout_switch.sv
module pkt_fanout_switch #(
    parameter int N_IN       = 3,
    parameter int N_OUT      = 4,
    parameter int WIDE_W     = 512,
    parameter int NARROW_W   = 128,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [N_IN-1:0]                           s_valid,
    output logic [N_IN-1:0]                           s_ready,
    input  logic [N_IN-1:0][WIDE_W-1:0]               s_data,
    input  logic [N_IN-1:0][WIDE_W/8-1:0]             s_keep,
    input  logic [N_IN-1:0]                           s_last,
    input  logic [N_IN-1:0][$clog2(N_OUT)-1:0]        s_dest,
    output logic [N_OUT-1:0]                          m_valid,
    input  logic [N_OUT-1:0]                          m_ready,
    output logic [N_OUT-1:0][NARROW_W-1:0]            m_data,
    output logic [N_OUT-1:0][NARROW_W/8-1:0]          m_keep,
    output logic [N_OUT-1:0]                          m_last
);

    localparam int KEEP_W  = WIDE_W / 8;
    localparam int NKEEP_W = NARROW_W / 8;
    localparam int DEST_W  = $clog2(N_OUT);

    // head of each input FIFO
    logic [N_IN-1:0]                 hd_valid;
    logic [N_IN-1:0][WIDE_W-1:0]     hd_data;
    logic [N_IN-1:0][KEEP_W-1:0]     hd_keep;
    logic [N_IN-1:0]                 hd_last;
    logic [N_IN-1:0][DEST_W-1:0]     hd_dest;
    logic [N_IN-1:0]                 hd_pop;

    // narrow stream of each input
    logic [N_IN-1:0]                 nb_valid;
    logic [N_IN-1:0]                 nb_ready;
    logic [N_IN-1:0][NARROW_W-1:0]   nb_data;
    logic [N_IN-1:0][NKEEP_W-1:0]    nb_keep;
    logic [N_IN-1:0]                 nb_last;
    logic [N_IN-1:0][DEST_W-1:0]     nb_dest;

    // per-output grant vectors
    logic [N_OUT-1:0][N_IN-1:0]      arb_gnt;
    logic [N_OUT-1:0][N_IN-1:0]      arb_gnt_rdy;

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_in
        pfs_ingress #(
            .WIDE_W (WIDE_W),
            .DEST_W (DEST_W),
            .DEPTH  (FIFO_DEPTH)
        ) u_ingress (
            .clk     (clk),
            .rst_n   (rst_n),
            .s_valid (s_valid[gi]),
            .s_ready (s_ready[gi]),
            .s_data  (s_data[gi]),
            .s_keep  (s_keep[gi]),
            .s_last  (s_last[gi]),
            .s_dest  (s_dest[gi]),
            .h_valid (hd_valid[gi]),
            .h_data  (hd_data[gi]),
            .h_keep  (hd_keep[gi]),
            .h_last  (hd_last[gi]),
            .h_dest  (hd_dest[gi]),
            .pop     (hd_pop[gi])
        );

        pfs_narrower #(
            .WIDE_W   (WIDE_W),
            .NARROW_W (NARROW_W),
            .DEST_W   (DEST_W)
        ) u_narrow (
            .clk     (clk),
            .rst_n   (rst_n),
            .h_valid (hd_valid[gi]),
            .h_data  (hd_data[gi]),
            .h_keep  (hd_keep[gi]),
            .h_last  (hd_last[gi]),
            .h_dest  (hd_dest[gi]),
            .pop     (hd_pop[gi]),
            .n_valid (nb_valid[gi]),
            .n_ready (nb_ready[gi]),
            .n_data  (nb_data[gi]),
            .n_keep  (nb_keep[gi]),
            .n_last  (nb_last[gi]),
            .n_dest  (nb_dest[gi])
        );
    end

    for (genvar go = 0; go < N_OUT; go++) begin : g_out
        pfs_out_arb #(
            .N_IN     (N_IN),
            .NARROW_W (NARROW_W),
            .DEST_W   (DEST_W),
            .OUT_ID   (go)
        ) u_arb (
            .clk       (clk),
            .rst_n     (rst_n),
            .n_valid   (nb_valid),
            .n_dest    (nb_dest),
            .n_data    (nb_data),
            .n_keep    (nb_keep),
            .n_last    (nb_last),
            .m_valid   (m_valid[go]),
            .m_ready   (m_ready[go]),
            .m_data    (m_data[go]),
            .m_keep    (m_keep[go]),
            .m_last    (m_last[go]),
            .gnt       (arb_gnt[go]),
            .gnt_ready (arb_gnt_rdy[go])
        );
    end

    // an input advances only through the output that holds its grant
    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            nb_ready[i] = 1'b0;
            for (int o = 0; o < N_OUT; o++) begin
                nb_ready[i] = nb_ready[i] | arb_gnt_rdy[o][i];
            end
        end
    end

endmodule

// File: rtl/pfs_checker.sv
module pfs_checker #(
    parameter int N_IN     = 3,
    parameter int N_OUT    = 4,
    parameter int NARROW_W = 128,
    parameter int NKEEP_W  = 16
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [N_IN-1:0]                   s_valid,
    input logic [N_IN-1:0]                   s_ready,
    input logic [N_OUT-1:0]                  m_valid,
    input logic [N_OUT-1:0]                  m_ready,
    input logic [N_OUT-1:0][NARROW_W-1:0]    m_data,
    input logic [N_OUT-1:0][NKEEP_W-1:0]     m_keep,
    input logic [N_OUT-1:0]                  m_last,
    input logic [N_OUT-1:0][N_IN-1:0]        arb_gnt
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_o
        // R10: a stalled beat is held unchanged
        p_hold_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (m_valid[o] && !m_ready[o]) |=> (m_valid[o] && $stable(m_data[o])
                && $stable(m_keep[o]) && $stable(m_last[o])));

        // R7: at most one input owns an output
        p_onehot_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(arb_gnt[o]));

        // R6: a grant is kept until the last narrow beat is taken
        p_grant_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ((|arb_gnt[o]) && !(m_valid[o] && m_ready[o] && m_last[o]))
                |=> (arb_gnt[o] == $past(arb_gnt[o])));
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_i
        // R8: ready only drops after a beat was offered (FIFO filling)
        p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(s_ready[i]) |-> $past(s_valid[i]));
    end

endmodule

bind pkt_fanout_switch pfs_checker #(
    .N_IN     (N_IN),
    .N_OUT    (N_OUT),
    .NARROW_W (NARROW_W),
    .NKEEP_W  (NKEEP_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_data  (m_data),
    .m_keep  (m_keep),
    .m_last  (m_last),
    .arb_gnt (arb_gnt)
);

// File: tb/sim_pkt_fanout_switch.sv
module sim_pkt_fanout_switch;

    localparam int CLK_PERIOD = 10;
    localparam int NI    = 3;
    localparam int NO    = 4;
    localparam int WW    = 512;
    localparam int NW    = 128;
    localparam int DEPTH = 4;
    localparam int KW    = WW / 8;
    localparam int NKW   = NW / 8;
    localparam int LOGN  = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [NI-1:0]           s_valid;
    logic [NI-1:0]           s_ready;
    logic [NI-1:0][WW-1:0]   s_data;
    logic [NI-1:0][KW-1:0]   s_keep;
    logic [NI-1:0]           s_last;
    logic [NI-1:0][1:0]      s_dest;
    logic [NO-1:0]           m_valid;
    logic [NO-1:0]           m_ready;
    logic [NO-1:0][NW-1:0]   m_data;
    logic [NO-1:0][NKW-1:0]  m_keep;
    logic [NO-1:0]           m_last;

    pkt_fanout_switch #(
        .N_IN(NI), .N_OUT(NO), .WIDE_W(WW), .NARROW_W(NW), .FIFO_DEPTH(DEPTH)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_keep(s_keep),
        .s_last(s_last), .s_dest(s_dest),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_keep(m_keep),
        .m_last(m_last)
    );

    int checks = 0;
    int failures = 0;

    logic [NW-1:0]  lg_data [NO][LOGN];
    logic [NKW-1:0] lg_keep [NO][LOGN];
    logic           lg_last [NO][LOGN];
    int             lg_n [NO];
    int             rd [NO];
    int             acc_cnt [NI];
    int             stab_err = 0;

    logic [NO-1:0]           force_low = '0;
    logic                    rand_rdy = 1'b0;
    logic [15:0]             lfsr = 16'hACE1;
    logic [NO-1:0]           pv = '0;
    logic [NO-1:0]           pr = '0;
    logic [NO-1:0][NW-1:0]   pd;
    logic [NO-1:0][NKW-1:0]  pk;
    logic [NO-1:0]           pl;

    // sink ready driver
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        for (int o = 0; o < NO; o++) begin
            m_ready[o] <= force_low[o] ? 1'b0 : (rand_rdy ? lfsr[o*3] : 1'b1);
        end
    end

    // output monitor
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int o = 0; o < NO; o++) lg_n[o] <= 0;
        end else begin
            for (int o = 0; o < NO; o++) begin
                if (m_valid[o] && m_ready[o] && lg_n[o] < LOGN) begin
                    lg_data[o][lg_n[o]] <= m_data[o];
                    lg_keep[o][lg_n[o]] <= m_keep[o];
                    lg_last[o][lg_n[o]] <= m_last[o];
                    lg_n[o] <= lg_n[o] + 1;
                end
                if (pv[o] && !pr[o] && (!m_valid[o] || m_data[o] != pd[o]
                        || m_keep[o] != pk[o] || m_last[o] != pl[o]))
                    stab_err <= stab_err + 1;
            end
        end
        pv <= m_valid;
        pr <= m_ready;
        pd <= m_data;
        pk <= m_keep;
        pl <= m_last;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [NW-1:0] lane_val(int i, int p, int b, int k);
        return {16'hA5A5, 16'(i), 32'(p), 32'(b), 32'(k)};
    endfunction

    function automatic logic [KW-1:0] keep_of(bit last, int nbytes);
        logic [KW-1:0] kv;
        for (int j = 0; j < KW; j++) kv[j] = (!last) || (j < nbytes);
        return kv;
    endfunction

    task automatic drain(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        s_valid = '0;
        s_last = '0;
        s_dest = '0;
        s_data = '0;
        s_keep = '0;
        force_low = '0;
        rand_rdy = 1'b0;
        repeat (3) @(negedge clk);
        for (int o = 0; o < NO; o++) rd[o] = 0;
        for (int i = 0; i < NI; i++) acc_cnt[i] = 0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // drive one packet on input i; beats after the first carry alt_dest
    task automatic send_pkt(int i, int d, int p, int nbeats, int nbytes, int alt_dest);
        bit ok;
        @(negedge clk);
        for (int b = 0; b < nbeats; b++) begin
            s_valid[i] = 1'b1;
            for (int k = 0; k < 4; k++) s_data[i][k*NW +: NW] = lane_val(i, p, b, k);
            s_keep[i] = keep_of(b == nbeats - 1, nbytes);
            s_last[i] = (b == nbeats - 1);
            s_dest[i] = (b == 0) ? 2'(d) : 2'(alt_dest);
            forever begin
                ok = s_ready[i];
                @(negedge clk);
                if (ok) break;
            end
            acc_cnt[i]++;
        end
        s_valid[i] = 1'b0;
        s_last[i] = 1'b0;
    endtask

    // compare the next beats logged on output o against one expected packet
    task automatic expect_pkt(int o, int i, int p, int nbeats, int nbytes, string req);
        bit ok = 1'b1;
        logic [127:0] a = '0;
        logic [127:0] e = '0;
        logic [KW-1:0] kw;
        for (int b = 0; b < nbeats; b++) begin
            int segs = (b == nbeats - 1) ? (nbytes + 15) / 16 : 4;
            kw = keep_of(b == nbeats - 1, nbytes);
            for (int k = 0; k < segs; k++) begin
                int idx = rd[o];
                bit el = (b == nbeats - 1) && (k == segs - 1);
                if (idx >= lg_n[o]) begin
                    if (ok) begin a = 128'(lg_n[o]); e = 128'(idx + 1); end
                    ok = 1'b0;
                end else if (lg_data[o][idx] != lane_val(i, p, b, k)
                             || lg_keep[o][idx] != kw[k*NKW +: NKW]
                             || lg_last[o][idx] != el) begin
                    if (ok) begin a = lg_data[o][idx]; e = lane_val(i, p, b, k); end
                    ok = 1'b0;
                end
                rd[o]++;
            end
        end
        chk(ok, req, $sformatf("out%0d pkt%0d from in%0d", o, p, i), a, e);
    endtask

    task automatic expect_none(int o, string req);
        chk(lg_n[o] == rd[o], req, $sformatf("out%0d extra beats", o),
            128'(lg_n[o]), 128'(rd[o]));
    endtask

    initial begin
        fork
            begin : main_flow
                // R1: reset state
                rst_n = 1'b0;
                s_valid = '0;
                s_last = '0;
                s_dest = '0;
                s_data = '0;
                s_keep = '0;
                repeat (3) @(negedge clk);
                chk(m_valid == '0, "R1", "m_valid in reset", 128'(m_valid), 0);
                chk(s_ready == '1, "R1", "s_ready in reset", 128'(s_ready), 128'(3'b111));
                do_reset();
                chk(m_valid == '0, "R1", "m_valid after reset", 128'(m_valid), 0);
                chk(s_ready == '1, "R1", "s_ready after reset", 128'(s_ready), 128'(3'b111));

                // R2 / R4: every input to every output, varied lengths
                for (int i = 0; i < NI; i++) begin
                    for (int d = 0; d < NO; d++) begin
                        rand_rdy = (i == 2);
                        send_pkt(i, d, i*4 + d, 1 + (i + d) % 3, 1 + ((i*4 + d)*13) % 64, d);
                        drain(40);
                        expect_pkt(d, i, i*4 + d, 1 + (i + d) % 3, 1 + ((i*4 + d)*13) % 64,
                                   (d == 1) ? "R4" : "R2");
                    end
                end
                for (int o = 0; o < NO; o++) expect_none(o, "R2");

                // R5: every last-beat byte count
                do_reset();
                for (int nb = 1; nb <= 64; nb++) send_pkt(0, 2, 100 + nb, 1, nb, 2);
                drain(80);
                for (int nb = 1; nb <= 64; nb++) expect_pkt(2, 0, 100 + nb, 1, nb, "R5");
                expect_none(2, "R5");

                // R3: tag changes on later beats are ignored
                do_reset();
                send_pkt(1, 3, 7, 3, 40, 0);
                drain(40);
                expect_pkt(3, 1, 7, 3, 40, "R3");
                expect_none(0, "R3");

                // R7 / R6: three inputs contend for output 0
                do_reset();
                rand_rdy = 1'b1;
                fork
                    begin send_pkt(0, 0, 10, 2, 64, 0); send_pkt(0, 0, 11, 2, 20, 0); end
                    begin send_pkt(1, 0, 20, 2, 33, 0); send_pkt(1, 0, 21, 2, 5, 0); end
                    begin send_pkt(2, 0, 30, 2, 48, 0); send_pkt(2, 0, 31, 2, 64, 0); end
                join
                drain(120);
                expect_pkt(0, 0, 10, 2, 64, "R7");
                expect_pkt(0, 1, 20, 2, 33, "R7");
                expect_pkt(0, 2, 30, 2, 48, "R7");
                expect_pkt(0, 0, 11, 2, 20, "R6");
                expect_pkt(0, 1, 21, 2, 5, "R6");
                expect_pkt(0, 2, 31, 2, 64, "R6");
                expect_none(0, "R6");

                // R7: two contenders with the pointer at 0
                do_reset();
                fork
                    begin send_pkt(1, 3, 40, 1, 16, 3); send_pkt(1, 3, 41, 1, 16, 3); end
                    begin send_pkt(2, 3, 50, 1, 16, 3); send_pkt(2, 3, 51, 1, 16, 3); end
                join
                drain(40);
                expect_pkt(3, 1, 40, 1, 16, "R7");
                expect_pkt(3, 2, 50, 1, 16, "R7");
                expect_pkt(3, 1, 41, 1, 16, "R7");
                expect_pkt(3, 2, 51, 1, 16, "R7");

                // R9: a stalled output does not block another
                do_reset();
                force_low[0] = 1'b1;
                fork
                    send_pkt(0, 0, 60, 2, 64, 0);
                    send_pkt(1, 1, 61, 2, 64, 1);
                join
                drain(40);
                expect_pkt(1, 1, 61, 2, 64, "R9");
                chk(lg_n[0] == 0, "R9", "stalled out0 beats", 128'(lg_n[0]), 0);
                force_low[0] = 1'b0;
                drain(30);
                expect_pkt(0, 0, 60, 2, 64, "R9");

                // R8: FIFO fills to its depth, then ready drops
                do_reset();
                force_low = '1;
                fork
                    send_pkt(2, 3, 70, 6, 64, 3);
                    begin
                        drain(20);
                        chk(acc_cnt[2] == DEPTH, "R8", "beats accepted while full",
                            128'(acc_cnt[2]), 128'(DEPTH));
                        chk(s_ready[2] == 1'b0, "R8", "s_ready when full",
                            128'(s_ready[2]), 0);
                        force_low = '0;
                    end
                join
                drain(40);
                expect_pkt(3, 2, 70, 6, 64, "R8");

                // R10: stalled beats held steady across all runs
                chk(stab_err == 0, "R10", "stall stability violations", 128'(stab_err), 0);
            end
            begin : watchdog
                repeat (100000) @(posedge clk);
                failures++;
                $display("FAIL watchdog expired actual=hang expected=finish");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule